// File: doc/BRIEF.md
# Masked-Compare PWM and Overflow Pin Generator

This block turns a prescaled 16-bit down counter into two output waveforms. The first is a pulse-width waveform. It is built from two masked comparisons. A zero event occurs when the counter ANDed with the active mask is zero. A compare event occurs when the counter ANDed with the mask equals the compare value ANDed with the mask. In set/reset mode, the zero event starts each period and the compare event ends the active phase, so the compare value sets the duty cycle. The top set bit of the mask cuts the period down to a power of two. In toggle mode, the pin inverts on every compare event, which gives a 50% duty cycle at half the frequency.

The second output is the overflow pin. It reacts to counter underflow. When the counter leaves zero, it reloads either from the reload value or from all-ones (free running). On that same edge the overflow pin is set (set mode) or inverted (toggle mode). In set mode the pin stays high until software pulses the clear input. Mask and compare writes go to holding registers. They only become active at the next zero event, so a period that is already running is never cut short or glitched.

Top module: `maskpwm_unit`

## Requirements
- R1: Reset (asynchronous, active low) drives both pins to 0 and the counter to 0. It also sets the active mask and the active compare value to 0, so the first tick after reset already loads the holding registers.
- R2: When `pwm_en` is 0, `pwm_o` is 0 one clock later, whatever the other inputs are.
- R3: In set/reset mode (`pwm_toggle`=0), a zero event drives `pwm_o` to `pwm_pol`.
- R4: In set/reset mode, a compare event drives `pwm_o` to the inverse of `pwm_pol`. A compare event wins over a zero event on the same tick, so a masked compare value of 0 holds the pin at the inverse of `pwm_pol`. With mask 000Fh, compare 4 and polarity 1, the pin is high for 12 of every 16 ticks.
- R5: In toggle mode (`pwm_toggle`=1), `pwm_o` inverts on each compare event. With mask 000Fh the period is 32 ticks and the pin is high for 16 of them.
- R6: The counter changes, and events are evaluated, only in cycles where `tick` is 1. Each tick moves the counter down by one. When the counter leaves 0, it loads `reload_val` if `reload_en`=1, and FFFFh otherwise.
- R7: With mask bit n as the top set bit, the set/reset period is 2^(n+1) ticks.
- R8: In set mode (`ovf_toggle`=0), an underflow sets `ovf_o`. A pulse on `ovf_clr` clears it. When an underflow and a clear happen in the same cycle, the underflow wins.
- R9: In toggle mode (`ovf_toggle`=1), `ovf_o` inverts on each underflow and `ovf_clr` is ignored. With reload value 9 the period is 20 ticks.
- R10: A new `mask_in` or `cmp_in` value takes effect only for events after the next zero event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler tick; counter step enable |
| reload_en | input | 1 | 1: reload from `reload_val` on underflow; 0: wrap to all-ones |
| reload_val | input | 16 | Reload value |
| mask_in | input | 16 | Match mask (held until the next zero event) |
| cmp_in | input | 16 | Compare value (held until the next zero event) |
| pwm_en | input | 1 | PWM pin enable |
| pwm_pol | input | 1 | Level that a zero event drives in set/reset mode |
| pwm_toggle | input | 1 | 1: PWM toggle mode; 0: set/reset mode |
| ovf_toggle | input | 1 | 1: overflow pin toggle mode; 0: set mode |
| ovf_clr | input | 1 | Software clear of the overflow pin in set mode |
| pwm_o | output | 1 | PWM pin, registered |
| ovf_o | output | 1 | Overflow pin, registered |

## Verification
Two situations are hard to reach from the ports. The first is an underflow landing in the same cycle as a software clear. The bench gets there by holding `ovf_clr` high across an underflow, then checks that the pin still rises and falls on the following cycle. The second is the edge of the holding registers. The bench changes the compare value on the cycle right after a zero event has raised the pin. It then measures that the running period keeps the old duty and that the next period uses the new one. A behavioural model compares both pins every clock throughout, including runs with a sparse tick.

// File: rtl/mpw_pkg.sv
`timescale 1ns/1ps
package mpw_pkg;
   // Events produced on a tick, consumed by the pin logic
   typedef struct packed {
      logic zero_hit;   // (cnt & mask) == 0
      logic cmp_hit;    // (cnt & mask) == (cmp & mask)
      logic underflow;  // counter leaves zero
   } mpw_evt_t;
endpackage

// File: rtl/mpw_counter.sv
`timescale 1ns/1ps
module mpw_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         reload_en,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] cnt,
   output logic         underflow
);
   localparam logic [W-1:0] TOP  = '1;
   localparam logic [W-1:0] ZERO = '0;

   assign underflow = tick && (cnt == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= ZERO;
      else if (tick) begin
         if (cnt == ZERO)
            cnt <= reload_en ? reload_val : TOP;
         else
            cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/mpw_match.sv
`timescale 1ns/1ps
module mpw_match #(
   parameter int unsigned W      = 16,
   parameter bit          SHADOW = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] mask_in,
   input  logic [W-1:0] cmp_in,
   output logic         zero_hit,
   output logic         cmp_hit
);
   localparam logic [W-1:0] ZERO = '0;

   logic [W-1:0] act_mask;
   logic [W-1:0] act_cmp;
   logic [W-1:0] masked_cnt;

   assign masked_cnt = cnt & act_mask;
   assign zero_hit   = tick && (masked_cnt == ZERO);
   assign cmp_hit    = tick && (masked_cnt == (act_cmp & act_mask));

   generate
      if (SHADOW) begin : g_shadow
         // Holding registers become active at the zero event
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_mask <= ZERO;
               act_cmp  <= ZERO;
            end else if (zero_hit) begin
               act_mask <= mask_in;
               act_cmp  <= cmp_in;
            end
         end
      end else begin : g_direct
         assign act_mask = mask_in;
         assign act_cmp  = cmp_in;
      end
   endgenerate
endmodule

// File: rtl/mpw_pins.sv
`timescale 1ns/1ps
module mpw_pins
   import mpw_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  mpw_evt_t evt,
   input  logic     pwm_en,
   input  logic     pwm_pol,
   input  logic     pwm_toggle,
   input  logic     ovf_toggle,
   input  logic     ovf_clr,
   output logic     pwm_o,
   output logic     ovf_o
);
   logic pwm_nx;
   logic ovf_nx;

   always_comb begin
      pwm_nx = pwm_o;
      if (!pwm_en)
         pwm_nx = 1'b0;
      else if (pwm_toggle) begin
         if (evt.cmp_hit) pwm_nx = ~pwm_o;
      end else if (evt.cmp_hit)
         pwm_nx = ~pwm_pol;          // compare has priority
      else if (evt.zero_hit)
         pwm_nx = pwm_pol;
   end

   always_comb begin
      ovf_nx = ovf_o;
      if (ovf_toggle) begin
         if (evt.underflow) ovf_nx = ~ovf_o;
      end else if (evt.underflow)
         ovf_nx = 1'b1;              // underflow beats clear
      else if (ovf_clr)
         ovf_nx = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_o <= 1'b0;
         ovf_o <= 1'b0;
      end else begin
         pwm_o <= pwm_nx;
         ovf_o <= ovf_nx;
      end
   end
endmodule

// File: rtl/maskpwm_unit.sv
`timescale 1ns/1ps
module maskpwm_unit
   import mpw_pkg::*;
#(
   parameter int unsigned W      = 16,
   parameter bit          SHADOW = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         reload_en,
   input  logic [W-1:0] reload_val,
   input  logic [W-1:0] mask_in,
   input  logic [W-1:0] cmp_in,
   input  logic         pwm_en,
   input  logic         pwm_pol,
   input  logic         pwm_toggle,
   input  logic         ovf_toggle,
   input  logic         ovf_clr,
   output logic         pwm_o,
   output logic         ovf_o
);
   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("maskpwm_unit: W must lie in 2..32");
      end
   endgenerate

   logic [W-1:0] cnt;
   mpw_evt_t     evt;

   mpw_counter #(.W(W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .reload_en  (reload_en),
      .reload_val (reload_val),
      .cnt        (cnt),
      .underflow  (evt.underflow)
   );

   mpw_match #(.W(W), .SHADOW(SHADOW)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cnt      (cnt),
      .mask_in  (mask_in),
      .cmp_in   (cmp_in),
      .zero_hit (evt.zero_hit),
      .cmp_hit  (evt.cmp_hit)
   );

   mpw_pins u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .pwm_en     (pwm_en),
      .pwm_pol    (pwm_pol),
      .pwm_toggle (pwm_toggle),
      .ovf_toggle (ovf_toggle),
      .ovf_clr    (ovf_clr),
      .pwm_o      (pwm_o),
      .ovf_o      (ovf_o)
   );
endmodule

// File: rtl/mpw_checker.sv
`timescale 1ns/1ps
module mpw_checker (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic pwm_en,
   input logic ovf_toggle,
   input logic ovf_clr,
   input logic pwm_o,
   input logic ovf_o
);
   // R2: disabled PWM pin goes low on the next edge
   p_pwm_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_en |=> !pwm_o);

   // R6: without a tick an enabled PWM pin keeps its level
   p_pwm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && pwm_en) |=> $stable(pwm_o));

   // R8: set-mode overflow pin stays high until cleared
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_toggle && ovf_o && !ovf_clr) |=> ovf_o);

   // R8: overflow pin only rises on a tick (underflow)
   p_ovf_rise_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !$rose(ovf_o));

   // R9: toggle-mode overflow pin ignores clear and changes only on a tick
   p_ovf_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_toggle && !tick) |=> $stable(ovf_o));
endmodule

bind maskpwm_unit mpw_checker u_mpw_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .pwm_en     (pwm_en),
   .ovf_toggle (ovf_toggle),
   .ovf_clr    (ovf_clr),
   .pwm_o      (pwm_o),
   .ovf_o      (ovf_o)
);

// File: tb/test_maskpwm_unit.sv
`timescale 1ns/1ps
module test_maskpwm_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        reload_en = 1'b0;
   logic [15:0] reload_val = 16'd0;
   logic [15:0] mask_in = 16'd0;
   logic [15:0] cmp_in = 16'd0;
   logic        pwm_en = 1'b0, pwm_pol = 1'b0, pwm_toggle = 1'b0;
   logic        ovf_toggle = 1'b0, ovf_clr = 1'b0;
   logic        pwm_o, ovf_o;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    tick_div = 1;
   int    ph = 0;
   bit    mon_en = 1'b0;
   bit    done = 1'b0;
   string phase = "R1";

   always #5 clk = ~clk;

   maskpwm_unit i_maskpwm_unit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reload_en(reload_en),
      .reload_val(reload_val), .mask_in(mask_in), .cmp_in(cmp_in),
      .pwm_en(pwm_en), .pwm_pol(pwm_pol), .pwm_toggle(pwm_toggle),
      .ovf_toggle(ovf_toggle), .ovf_clr(ovf_clr), .pwm_o(pwm_o), .ovf_o(ovf_o)
   );

   task automatic check(input string tag, input longint got, input longint exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // Behavioural reference model
   int m_cnt, m_mask, m_cmp;
   bit m_pwm, m_ovf, e_z, e_c, e_u;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_mask = 0; m_cmp = 0; m_pwm = 0; m_ovf = 0;
      end else begin
         e_z = 0; e_c = 0; e_u = 0;
         if (tick) begin
            e_z = ((m_cnt & m_mask) == 0);
            e_c = ((m_cnt & m_mask) == (m_cmp & m_mask));
            e_u = (m_cnt == 0);
         end
         if (!pwm_en) m_pwm = 0;
         else if (pwm_toggle) begin if (e_c) m_pwm = !m_pwm; end
         else if (e_c) m_pwm = !pwm_pol;
         else if (e_z) m_pwm = pwm_pol;
         if (ovf_toggle) begin if (e_u) m_ovf = !m_ovf; end
         else if (e_u) m_ovf = 1;
         else if (ovf_clr) m_ovf = 0;
         if (e_z) begin m_mask = int'(mask_in); m_cmp = int'(cmp_in); end
         if (tick) m_cnt = e_u ? (reload_en ? int'(reload_val) : 65535) : m_cnt - 1;
      end
   end

   // Per-clock comparison against the model
   initial forever begin
      @(posedge clk); #2;
      if (mon_en) begin
         check({phase, " pwm_o vs model"}, pwm_o, m_pwm);
         check({phase, " ovf_o vs model"}, ovf_o, m_ovf);
      end
   end

   // Prescaler tick source
   initial forever begin
      @(negedge clk);
      ph  = (ph + 1) % tick_div;
      tick = (ph == 0);
   end

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      mon_en = 1'b1;
   endtask

   // Cycles to the next rising edge of the selected pin, and high cycles seen
   task automatic wait_rise(input bit sel, output int cyc, output int hi);
      bit prev, cur;
      cyc = 0; hi = 0;
      prev = sel ? ovf_o : pwm_o;
      forever begin
         @(posedge clk); #2;
         cyc++;
         cur = sel ? ovf_o : pwm_o;
         if (cur && !prev) break;
         if (cur) hi++;
         prev = cur;
      end
      @(negedge clk);
   endtask

   initial begin
      int per, hi, low_cnt;
      // R1: reset state
      do_reset();
      #2;
      check("R1 pwm_o after reset", pwm_o, 0);
      check("R1 ovf_o after reset", ovf_o, 0);

      // R2: disabled pin stays low
      phase = "R2";
      @(negedge clk);
      mask_in = 16'h000F; cmp_in = 16'd4; pwm_pol = 1; pwm_en = 0;
      low_cnt = 0;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #2;
         if (!pwm_o) low_cnt++;
      end
      check("R2 low cycles while disabled", low_cnt, 40);

      // R3/R4/R7: set/reset, pol 1, mask F, cmp 4
      phase = "R4";
      @(negedge clk); pwm_en = 1;
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      check("R7 period mask 000F", per, 16);
      check("R4 high cycles cmp 4 pol 1", hi + 1, 12);

      // R3: polarity 0
      phase = "R3";
      pwm_pol = 0;
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      check("R3 period pol 0", per, 16);
      check("R3 high cycles pol 0", hi + 1, 4);

      // R7: wider mask
      phase = "R7";
      pwm_pol = 1; mask_in = 16'h003F; cmp_in = 16'd8;
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      check("R7 period mask 003F", per, 64);
      check("R7 high cycles mask 003F cmp 8", hi + 1, 56);

      // R10: compare change right after a zero event
      phase = "R10";
      mask_in = 16'h000F; cmp_in = 16'd4;
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      cmp_in = 16'd8;
      low_cnt = 1;
      forever begin
         @(posedge clk); #2;
         if (!pwm_o) break;
         low_cnt++;
      end
      check("R10 running period keeps old compare", low_cnt, 12);
      @(negedge clk);
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      check("R10 next period uses new compare", hi + 1, 8);

      // R4: compare 0 coincides with zero event, compare wins
      phase = "R4";
      cmp_in = 16'd0;
      repeat (40) @(negedge clk);
      low_cnt = 0;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #2;
         if (!pwm_o) low_cnt++;
      end
      check("R4 compare 0 holds pin low", low_cnt, 40);

      // R5: toggle mode
      phase = "R5";
      @(negedge clk); cmp_in = 16'd4; pwm_toggle = 1;
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      check("R5 toggle period", per, 32);
      check("R5 toggle high cycles", hi + 1, 16);

      // R6: sparse tick
      phase = "R6";
      pwm_toggle = 0; tick_div = 3;
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      wait_rise(0, per, hi);
      check("R6 period with tick every 3rd cycle", per, 48);
      tick_div = 1;

      // R9: reload and overflow toggle mode, clear ignored
      phase = "R9";
      reload_en = 1; reload_val = 16'd9; ovf_toggle = 1; ovf_clr = 1;
      do_reset();
      wait_rise(1, per, hi);
      wait_rise(1, per, hi);
      check("R9 overflow toggle period reload 9", per, 20);
      check("R9 overflow toggle high cycles", hi + 1, 10);
      ovf_clr = 0;

      // R8: set mode, sticky and clear, underflow beats clear
      phase = "R8";
      ovf_toggle = 0;
      repeat (25) @(negedge clk);
      #1;
      check("R8 pin sticky after underflow", ovf_o, 1);
      ovf_clr = 1;
      @(negedge clk); ovf_clr = 0;
      #1;
      check("R8 pin cleared by software", ovf_o, 0);
      ovf_clr = 1;
      wait_rise(1, per, hi);
      check("R8 underflow wins over held clear", per <= 11, 1);
      @(posedge clk); #2;
      check("R8 held clear lowers pin next cycle", ovf_o, 0);
      @(negedge clk); ovf_clr = 0;

      // R6: free run wrap after reload disabled
      phase = "R6";
      reload_en = 0;
      repeat (30) @(negedge clk);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule